// File: doc/BRIEF.md
# DMA Address Window Decoder

This block sits beside a DMA engine and decides which DRAM chip-select window, if any, a transfer address belongs to. Software programs up to `NUM_WIN` windows. Each window has four settings: a base address, a size mask, an attribute byte that encodes the chip select, and an enable bit. A two-bit access right per window is packed into one shared control word.

The engine presents a 32-bit address and a read/write flag. One clock later the block returns the result. The result has a hit flag and a miss flag, the index of the matching window, that window's attribute byte, and a flag that is raised when the window forbids the requested direction. When windows overlap, the lowest-numbered one wins.

Software reaches the registers through a plain word-addressed port. Writes are synchronous and reads are combinational.

Top module: `dma_win_decode`

## Requirements
- R1: After reset every register reads as zero, every window is disabled, and each lookup reports a miss.
- R2: Register word map: 0 is control, 1 is override, 2+i is the base of window i, and 2+NUM_WIN+i is the mask of window i. The control word keeps only bits [NUM_WIN-1:0] and bits [16+2*NUM_WIN-1:16]. A base word keeps bits [31:8]. A mask word keeps bits [31:16]. Bits that are not kept read as zero, and an address outside the map reads as zero.
- R3: Control bit i enables window i. A disabled window never hits.
- R4: An enabled window hits when (addr[31:16] & ~mask[31:16]) equals (base[31:16] & ~mask[31:16]). Address bits [15:0] are ignored, so windows have 64 KB granularity.
- R5: When more than one window hits, the lowest-numbered one is reported.
- R6: The reported attribute is bits [15:8] of the hitting window's base word. For chip-select windows those bits hold a value with one low bit per chip select: 0x0E, 0x0D, 0x0B and 0x07 for chip selects 0 to 3.
- R7: Control bits [16+2i+1:16+2i] are the rights of window i. Bit 16+2i allows reads and bit 16+2i+1 allows writes. A hit whose direction bit is clear still reports the hit and the window, and it also raises the violation flag.
- R8: On a miss, the miss flag is 1 and the hit flag, violation flag, window index and attribute are all 0.
- R9: A lookup presented in cycle n has its result valid after clock edge n+1. In a cycle that follows no lookup, the valid, hit, miss and violation flags, the index and the attribute are all 0.
- R10: The override word keeps all 32 bits and resets to 0. Its value has no effect on decoding.
- R11: A lookup presented in the same cycle as a register write is decoded with the settings from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Address to decode |
| lk_write | input | 1 | 1 for a write access, 0 for a read |
| rs_valid | output | 1 | Result valid |
| rs_hit | output | 1 | A window matched |
| rs_miss | output | 1 | No window matched |
| rs_win | output | 2 | Index of the matching window |
| rs_attr | output | 8 | Attribute byte of the matching window |
| rs_viol | output | 1 | Access right missing for the requested direction |

## Verification
The first pattern uses four disjoint windows carrying the chip-select attribute codes. This separates correct mask comparison and attribute steering from crossed windows. A fully overlapping layout, combined with selective enables, shows whether the lowest index wins and whether a disabled window is truly skipped. Four rights settings, each tried with both read and write, separate the read bit from the write bit. Addresses one byte inside and one byte past the edge of an exact 64 KB window, together with a write to the control word in the same cycle as a lookup, expose off-by-one granularity and early-update faults. Finally, a run of random addresses and random window rewrites is compared cycle by cycle against the model.

// File: rtl/dwd_pkg.sv
package dwd_pkg;
   localparam int unsigned DWD_DW       = 32;
   localparam int unsigned DWD_GRAN     = 16;
   localparam int unsigned DWD_HI_W     = DWD_DW - DWD_GRAN;
   localparam int unsigned DWD_ATTR_W   = 8;
   localparam int unsigned DWD_ATTR_LSB = 8;
   localparam int unsigned DWD_PERM_LSB = 16;

   typedef struct packed {
      logic [DWD_HI_W-1:0]   base_hi;
      logic [DWD_ATTR_W-1:0] attr;
      logic [DWD_HI_W-1:0]   mask_hi;
      logic                  en;
      logic                  rd_ok;
      logic                  wr_ok;
   } dwd_win_t;
endpackage

// File: rtl/dwd_regfile.sv
module dwd_regfile
   import dwd_pkg::*;
#(
   parameter int unsigned NUM_WIN = 4,
   parameter int unsigned RA_W    = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [RA_W-1:0]       addr,
   input  logic [DWD_DW-1:0]     wdata,
   output logic [DWD_DW-1:0]     rdata,
   output dwd_win_t [NUM_WIN-1:0] win_o
);
   localparam int unsigned OFS_CTL  = 0;
   localparam int unsigned OFS_OVR  = 1;
   localparam int unsigned OFS_BASE = 2;
   localparam int unsigned OFS_MASK = 2 + NUM_WIN;
   localparam int unsigned N_WORDS  = 2 + 2 * NUM_WIN;

   if (N_WORDS > (1 << RA_W)) begin : g_bad_map
      $error("dwd_regfile: register map does not fit RA_W");
   end

   logic [NUM_WIN-1:0]   en_q;
   logic [2*NUM_WIN-1:0] perm_q;
   logic [DWD_DW-1:0]    ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         perm_q <= '0;
         ovr_q  <= '0;
      end else if (we) begin
         if (addr == RA_W'(OFS_CTL)) begin
            en_q   <= wdata[NUM_WIN-1:0];
            perm_q <= wdata[DWD_PERM_LSB +: 2*NUM_WIN];
         end
         if (addr == RA_W'(OFS_OVR)) ovr_q <= wdata;
      end
   end

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      logic [DWD_HI_W-1:0]   base_q;
      logic [DWD_ATTR_W-1:0] attr_q;
      logic [DWD_HI_W-1:0]   mask_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q <= '0;
            attr_q <= '0;
            mask_q <= '0;
         end else if (we) begin
            if (addr == RA_W'(OFS_BASE + i)) begin
               base_q <= wdata[DWD_DW-1 -: DWD_HI_W];
               attr_q <= wdata[DWD_ATTR_LSB +: DWD_ATTR_W];
            end
            if (addr == RA_W'(OFS_MASK + i)) mask_q <= wdata[DWD_DW-1 -: DWD_HI_W];
         end
      end

      assign win_o[i].base_hi = base_q;
      assign win_o[i].attr    = attr_q;
      assign win_o[i].mask_hi = mask_q;
      assign win_o[i].en      = en_q[i];
      assign win_o[i].rd_ok   = perm_q[2*i];
      assign win_o[i].wr_ok   = perm_q[2*i+1];
   end

   always_comb begin
      rdata = '0;
      if (addr == RA_W'(OFS_CTL)) begin
         rdata[NUM_WIN-1:0]                 = en_q;
         rdata[DWD_PERM_LSB +: 2*NUM_WIN]   = perm_q;
      end
      if (addr == RA_W'(OFS_OVR)) rdata = ovr_q;
      for (int k = 0; k < NUM_WIN; k++) begin
         if (addr == RA_W'(OFS_BASE + k)) begin
            rdata[DWD_DW-1 -: DWD_HI_W]        = win_o[k].base_hi;
            rdata[DWD_ATTR_LSB +: DWD_ATTR_W]  = win_o[k].attr;
         end
         if (addr == RA_W'(OFS_MASK + k))
            rdata[DWD_DW-1 -: DWD_HI_W] = win_o[k].mask_hi;
      end
   end

   // R10
   ovr_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == RA_W'(OFS_OVR)) |=> $stable(win_o));
endmodule

// File: rtl/dwd_match.sv
module dwd_match
   import dwd_pkg::*;
#(
   parameter int unsigned NUM_WIN = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [DWD_HI_W-1:0]    addr_hi,
   input  dwd_win_t [NUM_WIN-1:0] win_i,
   output logic [NUM_WIN-1:0]     hit_vec
);
   for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
      logic [DWD_HI_W-1:0] diff;
      assign diff       = (addr_hi ^ win_i[i].base_hi) & ~win_i[i].mask_hi;
      assign hit_vec[i] = win_i[i].en && (diff == '0);

      // R3
      dis_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !win_i[i].en |-> !hit_vec[i]);
   end
endmodule

// File: rtl/dwd_prio.sv
module dwd_prio #(
   parameter int unsigned NUM_WIN = 4,
   localparam int unsigned IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_WIN-1:0] req,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   if (NUM_WIN == 1) begin : g_single
      assign any = req[0];
      assign idx = '0;
   end else begin : g_scan
      always_comb begin
         any = 1'b0;
         idx = '0;
         for (int k = NUM_WIN - 1; k >= 0; k--) begin
            if (req[k]) begin
               any = 1'b1;
               idx = IDX_W'(k);
            end
         end
      end
   end

   // R5
   low_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req[0] |-> (any && idx == '0));
endmodule

// File: rtl/dma_win_decode.sv
module dma_win_decode
   import dwd_pkg::*;
#(
   parameter int unsigned NUM_WIN = 4,
   parameter int unsigned RA_W    = 4,
   localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [RA_W-1:0]       reg_addr,
   input  logic [DWD_DW-1:0]     reg_wdata,
   output logic [DWD_DW-1:0]     reg_rdata,
   input  logic                  lk_valid,
   input  logic [DWD_DW-1:0]     lk_addr,
   input  logic                  lk_write,
   output logic                  rs_valid,
   output logic                  rs_hit,
   output logic                  rs_miss,
   output logic [IDX_W-1:0]      rs_win,
   output logic [DWD_ATTR_W-1:0] rs_attr,
   output logic                  rs_viol
);
   if (NUM_WIN < 1 || NUM_WIN > 8) begin : g_bad_count
      $error("dma_win_decode: NUM_WIN must be 1..8");
   end

   dwd_win_t [NUM_WIN-1:0] win;
   logic [NUM_WIN-1:0]     hit_vec;
   logic                   any_hit;
   logic [IDX_W-1:0]       sel;
   dwd_win_t               chosen;
   logic                   allowed;

   dwd_regfile #(.NUM_WIN(NUM_WIN), .RA_W(RA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .win_o(win));

   dwd_match #(.NUM_WIN(NUM_WIN)) u_match (
      .clk(clk), .rst_n(rst_n),
      .addr_hi(lk_addr[DWD_DW-1 -: DWD_HI_W]), .win_i(win), .hit_vec(hit_vec));

   dwd_prio #(.NUM_WIN(NUM_WIN)) u_prio (
      .clk(clk), .rst_n(rst_n), .req(hit_vec), .any(any_hit), .idx(sel));

   assign chosen  = win[sel];
   assign allowed = lk_write ? chosen.wr_ok : chosen.rd_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rs_valid <= 1'b0;
         rs_hit   <= 1'b0;
         rs_miss  <= 1'b0;
         rs_win   <= '0;
         rs_attr  <= '0;
         rs_viol  <= 1'b0;
      end else begin
         rs_valid <= lk_valid;
         rs_hit   <= lk_valid && any_hit;
         rs_miss  <= lk_valid && !any_hit;
         rs_win   <= (lk_valid && any_hit) ? sel : '0;
         rs_attr  <= (lk_valid && any_hit) ? chosen.attr : '0;
         rs_viol  <= lk_valid && any_hit && !allowed;
      end
   end

   // R9
   result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rs_valid);
   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_valid |-> (!rs_hit && !rs_miss && !rs_viol && rs_attr == '0));
   // R8
   miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rs_miss |-> (!rs_hit && !rs_viol && rs_attr == '0 && rs_win == '0));
   // R7
   viol_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rs_viol |-> rs_hit);
endmodule

// File: tb/dma_win_decode_test.sv
module dma_win_decode_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        lk_write = 1'b0;
   logic        rs_valid, rs_hit, rs_miss, rs_viol;
   logic [1:0]  rs_win;
   logic [7:0]  rs_attr;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   dma_win_decode uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
      .lk_addr(lk_addr), .lk_write(lk_write), .rs_valid(rs_valid),
      .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_win(rs_win),
      .rs_attr(rs_attr), .rs_viol(rs_viol));

   // behavioural model state
   bit [3:0]  m_en;
   bit [7:0]  m_perm;
   bit [31:0] m_ovr;
   bit [15:0] m_base[4];
   bit [7:0]  m_attr[4];
   bit [15:0] m_mask[4];

   function automatic bit [31:0] m_read(bit [3:0] a);
      if (a == 0) return {8'h0, m_perm, 12'h0, m_en};
      if (a == 1) return m_ovr;
      if (a >= 2 && a <= 5) return {m_base[a-2], m_attr[a-2], 8'h0};
      if (a >= 6 && a <= 9) return {m_mask[a-6], 16'h0};
      return 32'h0;
   endfunction

   function automatic void m_write(bit [3:0] a, bit [31:0] d);
      if (a == 0) begin m_en = d[3:0]; m_perm = d[23:16]; end
      else if (a == 1) m_ovr = d;
      else if (a >= 2 && a <= 5) begin m_base[a-2] = d[31:16]; m_attr[a-2] = d[15:8]; end
      else if (a >= 6 && a <= 9) m_mask[a-6] = d[31:16];
   endfunction

   task automatic check(string tag, string what, bit [31:0] act, bit [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, check readback, clock, check result
   task automatic step(bit we, bit [3:0] a, bit [31:0] d, bit lv, bit [31:0] la, bit lw, string tag);
      bit e_v, e_h, e_m, e_x;
      bit [1:0] e_w;
      bit [7:0] e_a;
      reg_we = we; reg_addr = a; reg_wdata = d;
      lk_valid = lv; lk_addr = la; lk_write = lw;
      e_v = lv; e_h = 0; e_m = lv; e_x = 0; e_w = 0; e_a = 0;
      if (lv) begin
         for (int i = 3; i >= 0; i--) begin
            if (m_en[i] && (((la[31:16] ^ m_base[i]) & ~m_mask[i]) == 16'h0)) begin
               e_h = 1; e_m = 0; e_w = 2'(i); e_a = m_attr[i];
               e_x = !m_perm[2*i + int'(lw)];
            end
         end
      end
      #1;
      check(tag, "rdata", reg_rdata, m_read(a));
      @(posedge clk);
      if (we) m_write(a, d);
      @(negedge clk);
      check(tag, "valid", 32'(rs_valid), 32'(e_v));
      check(tag, "hit", 32'(rs_hit), 32'(e_h));
      check(tag, "miss", 32'(rs_miss), 32'(e_m));
      check(tag, "win", 32'(rs_win), 32'(e_w));
      check(tag, "attr", 32'(rs_attr), 32'(e_a));
      check(tag, "viol", 32'(rs_viol), 32'(e_x));
   endtask

   task automatic wr(bit [3:0] a, bit [31:0] d, string tag);
      step(1, a, d, 0, 0, 0, tag);
   endtask

   task automatic look(bit [31:0] la, bit lw, string tag);
      step(0, 0, 0, 1, la, lw, tag);
   endtask

   initial begin : watchdog
      while (cycles < 50000) begin
         @(posedge clk);
         cycles++;
      end
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      m_en = 0; m_perm = 0; m_ovr = 0;
      for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_attr[i] = 0; m_mask[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset readback and miss
      for (int a = 0; a < 16; a++) step(0, 4'(a), 0, 1, 32'(a) << 28, a[0], "R1");

      // R2: all-ones written everywhere, kept fields read back
      for (int a = 0; a < 16; a++) wr(4'(a), 32'hFFFF_FFFF, "R2");
      for (int a = 0; a < 16; a++) step(0, 4'(a), 0, 0, 0, 0, "R2");

      // R6 / R4: disjoint chip-select windows of 512 MB
      wr(2, 32'h0000_0E00, "R6"); wr(3, 32'h2000_0D00, "R6");
      wr(4, 32'h4000_0B00, "R6"); wr(5, 32'h6000_0700, "R6");
      for (int i = 6; i < 10; i++) wr(4'(i), 32'h1FFF_0000, "R4");
      wr(0, 32'h00FF_000F, "R3");
      for (int i = 0; i < 4; i++) begin
         look(32'(i) * 32'h2000_0000 + 32'h0123_4567, 0, "R6");
         look(32'(i) * 32'h2000_0000 + 32'h1FFF_FFFF, 1, "R4");
      end
      // R8: past the last window
      look(32'h8000_0000, 0, "R8");
      look(32'hFFFF_FFFF, 1, "R8");

      // R3: window 2 disabled
      wr(0, 32'h00FF_000B, "R3");
      look(32'h4000_1000, 0, "R3");
      look(32'h2000_1000, 0, "R3");

      // R5: overlapping windows, window 1 covers all
      wr(7, 32'hFFFF_0000, "R5");
      wr(0, 32'h00FF_000F, "R5");
      look(32'h0000_0010, 0, "R5");
      look(32'h6000_0010, 0, "R5");
      wr(0, 32'h00FF_000E, "R5");
      look(32'h0000_0010, 0, "R5");
      wr(0, 32'h00FF_000C, "R5");
      look(32'h6000_0010, 1, "R5");
      look(32'h0000_0010, 1, "R5");
      wr(7, 32'h1FFF_0000, "R5");

      // R7: rights read-only, write-only, none, both
      wr(0, 32'h00C9_000F, "R7");
      for (int i = 0; i < 4; i++) begin
         look(32'(i) * 32'h2000_0000 + 32'h40, 0, "R7");
         look(32'(i) * 32'h2000_0000 + 32'h40, 1, "R7");
      end

      // R9: gaps and back-to-back lookups
      step(0, 0, 0, 0, 0, 0, "R9");
      look(32'h2000_0000, 1, "R9");
      look(32'h9000_0000, 0, "R9");
      step(0, 1, 0, 0, 32'h2000_0000, 1, "R9");

      // R10: override written, decode unchanged
      wr(1, 32'hA5A5_5A5A, "R10");
      step(0, 1, 0, 1, 32'h2000_0004, 1, "R10");
      wr(1, 32'h0000_0000, "R10");
      look(32'h4000_0004, 0, "R10");

      // R4: exact 64 KB window edges
      wr(9, 32'h0000_0000, "R4");
      wr(5, 32'h7123_0700, "R4");
      wr(0, 32'h00FF_0008, "R4");
      look(32'h7123_0000, 0, "R4");
      look(32'h7123_FFFF, 1, "R4");
      look(32'h7124_0000, 0, "R4");
      look(32'h7122_FFFF, 0, "R4");

      // R11: write and lookup in the same cycle
      step(1, 0, 32'h0000_0000, 1, 32'h7123_0100, 0, "R11");
      look(32'h7123_0100, 0, "R11");
      step(1, 0, 32'h00FF_000F, 1, 32'h7123_0100, 0, "R11");
      look(32'h7123_0100, 0, "R11");

      // R4: random mix of lookups and window rewrites
      for (int n = 0; n < 600; n++) begin
         int unsigned r;
         r = $urandom;
         if (r[3:0] == 0)
            step(1, 4'(r[7:4] % 10), {$urandom} | 32'h0, 0, 0, 0, "R4");
         else
            step(0, 4'(r[11:8]), 0, 1, {r[31:29], 13'(r[28:16] & 13'h3), r[15:0]}, r[12], "R4");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule